// File: doc/BRIEF.md
# Path Alarm Signal Inserter

This block sits in the outgoing byte stream of an STS-1 path. It decides, once per frame, whether the path must be replaced by the path alarm indication signal (AIS). When AIS is on, it overwrites the three pointer bytes and the whole payload envelope with all-ones bytes. The other transport overhead bytes pass through untouched. The block does not interpret pointers or detect defects. It only combines defect flags that other logic has already raised.

The AIS decision is an OR of several sources:
- seven path defects: loss of pointer, incoming AIS, unequipped, label mismatch, trace mismatch, signal-fail and signal-degrade;
- four loss-of-sync defects;
- three loss-of-clock defects;
- a force bit set by software;
- a request line from the multiplexer side.

Each defect flag counts only while its own inhibit bit is low. The force bit and the external request cannot be masked. The decision is taken only at the byte marked by the frame-start strobe and is then held for the whole frame. AIS therefore begins and ends on frame boundaries, at most one frame after the cause appears or clears.

The block counts rows and columns of the 9-row by 90-column frame. A missing strobe does not stop the counter: it wraps on its own after 810 bytes. A strobe that arrives early resynchronises it.

Top module: `path_ais_inserter`

## Requirements
- R1: While rst_n is low, dout, dout_fs, ais_active and ais_change are all 0.
- R2: A path_def bit whose matching path_inh bit is 0 turns AIS on from the next frame-start byte. A path_def bit whose path_inh bit is 1 has no effect. Bit order of path_def and path_inh: 0 loss of pointer, 1 incoming AIS, 2 unequipped, 3 label mismatch, 4 trace mismatch, 5 signal-fail, 6 signal-degrade.
- R3: The same rule applies to los_def with los_inh (4 bits) and to loc_def with loc_inh (3 bits), bit for bit.
- R4: force_ais high at a frame-start byte turns AIS on for that frame, even when every inhibit bit is 1.
- R5: ext_ais_req high at a frame-start byte turns AIS on for that frame, even when every inhibit bit is 1.
- R6: The AIS decision is sampled only on the byte where din_fs is 1 and is held until the next such byte. Defect, force or request changes inside a frame have no effect until the next frame start.
- R7: While AIS is on, the bytes at row 4, columns 1 to 3 (1-based; the pointer bytes) are output as 8'hFF.
- R8: While AIS is on, every byte in columns 4 to 90 of every row is output as 8'hFF.
- R9: Transport overhead bytes other than the pointer bytes always pass unchanged. When AIS is off, every byte passes unchanged.
- R10: Each output byte appears one clock after its input byte, and dout_fs is din_fs delayed by one clock.
- R11: ais_active shows the AIS state applied to the current output byte. ais_change is a one-cycle pulse, coincident with dout_fs, in the frame where that state differs from the previous frame.
- R12: The byte after the last byte of a frame (row 9, column 90) is treated as row 1, column 1 even without a strobe. A strobe arriving at any position restarts the count at row 1, column 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 8 | Incoming STS-1 byte |
| din_fs | input | 1 | Marks the first byte of a frame |
| path_def | input | 7 | Path defect flags |
| path_inh | input | 7 | Inhibits for path_def, bit for bit |
| los_def | input | 4 | Loss-of-sync defect flags |
| los_inh | input | 4 | Inhibits for los_def |
| loc_def | input | 3 | Loss-of-clock defect flags |
| loc_inh | input | 3 | Inhibits for loc_def |
| force_ais | input | 1 | Software force, cannot be masked |
| ext_ais_req | input | 1 | Multiplexer-side AIS request, cannot be masked |
| dout | output | 8 | Outgoing byte |
| dout_fs | output | 1 | Frame-start strobe aligned with dout |
| ais_active | output | 1 | AIS state applied to the current dout |
| ais_change | output | 1 | Pulse in the first byte of a frame whose AIS state changed |

## Verification
Two events can fall in the same cycle:
- the per-frame re-evaluation of the AIS decision, and
- the restart of the position count.

Both happen on the strobe byte. That byte must take the new decision while being classed as row 1, column 1, where data always passes through.

The bench provokes this in three ways:
- it changes defect and inhibit inputs exactly between frames;
- it drops a strobe so that the counter wraps on its own while AIS stays held;
- it fires an early strobe in the middle of a frame.

The scoreboard then compares every output byte, strobe, state and change pulse against a model of position and frame state kept independently in the driver.

// File: rtl/path_ais_inserter.sv
`timescale 1ns/1ps
module path_ais_inserter #(
  parameter int ROWS     = 9,
  parameter int COLS     = 90,
  parameter int TOH_COLS = 3,
  parameter int PTR_ROW  = 3,
  parameter int N_PATH   = 7,
  parameter int N_LOS    = 4,
  parameter int N_LOC    = 3,
  parameter int W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      din,
  input  logic              din_fs,
  input  logic [N_PATH-1:0] path_def,
  input  logic [N_PATH-1:0] path_inh,
  input  logic [N_LOS-1:0]  los_def,
  input  logic [N_LOS-1:0]  los_inh,
  input  logic [N_LOC-1:0]  loc_def,
  input  logic [N_LOC-1:0]  loc_inh,
  input  logic              force_ais,
  input  logic              ext_ais_req,
  output logic [W-1:0]      dout,
  output logic              dout_fs,
  output logic              ais_active,
  output logic              ais_change
);
  localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;
  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
  localparam logic [CW-1:0] COL_LAST = CW'(COLS - 1);
  localparam logic [RW-1:0] ROW_PTR  = RW'(PTR_ROW);
  localparam logic [CW-1:0] COL_SPE  = CW'(TOH_COLS);

  logic [RW-1:0] row_q, row_n;
  logic [CW-1:0] col_q, col_n;
  logic          ais_q;

  always_comb begin
    if (din_fs) begin
      row_n = '0;
      col_n = '0;
    end else if (col_q == COL_LAST) begin
      col_n = '0;
      row_n = (row_q == ROW_LAST) ? '0 : row_q + 1'b1;
    end else begin
      col_n = col_q + 1'b1;
      row_n = row_q;
    end
  end

  wire gen_ais = (|(path_def & ~path_inh)) | (|(los_def & ~los_inh)) |
                 (|(loc_def & ~loc_inh)) | force_ais | ext_ais_req;
  wire cur_ais = din_fs ? gen_ais : ais_q;
  wire in_ptr  = (row_n == ROW_PTR) && (col_n < COL_SPE);
  wire in_spe  = (col_n >= COL_SPE);
  wire blank   = cur_ais && (in_ptr || in_spe);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q      <= ROW_LAST;
      col_q      <= COL_LAST;
      ais_q      <= 1'b0;
      dout       <= '0;
      dout_fs    <= 1'b0;
      ais_change <= 1'b0;
    end else begin
      row_q      <= row_n;
      col_q      <= col_n;
      ais_q      <= cur_ais;
      dout       <= blank ? {W{1'b1}} : din;
      dout_fs    <= din_fs;
      ais_change <= din_fs && (gen_ais != ais_q);
    end
  end

  assign ais_active = ais_q;
endmodule

// File: rtl/path_ais_inserter_chk.sv
`timescale 1ns/1ps
module path_ais_inserter_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] din,
  input logic         din_fs,
  input logic         force_ais,
  input logic         ext_ais_req,
  input logic [W-1:0] dout,
  input logic         dout_fs,
  input logic         ais_active,
  input logic         ais_change
);
  // R10
  fs_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (dout_fs == $past(din_fs)));
  // R4
  force_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (din_fs && force_ais) |=> ais_active);
  // R5
  ext_req_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (din_fs && ext_ais_req) |=> ais_active);
  // R6
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !din_fs |=> $stable(ais_active));
  // R11
  change_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ais_change |-> (dout_fs && (ais_active != $past(ais_active))));
  // R9
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ais_active || (dout == $past(din))));
endmodule

bind path_ais_inserter path_ais_inserter_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .din(din), .din_fs(din_fs),
  .force_ais(force_ais), .ext_ais_req(ext_ais_req),
  .dout(dout), .dout_fs(dout_fs), .ais_active(ais_active),
  .ais_change(ais_change)
);

// File: tb/path_ais_inserter_tb_top.sv
`timescale 1ns/1ps
module path_ais_inserter_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] din;
  logic       din_fs;
  logic [6:0] path_def, path_inh;
  logic [3:0] los_def, los_inh;
  logic [2:0] loc_def, loc_inh;
  logic       force_ais, ext_ais_req;
  logic [7:0] dout;
  logic       dout_fs, ais_active, ais_change;

  always #10 clk = ~clk;

  path_ais_inserter dut_i (
    .clk(clk), .rst_n(rst_n), .din(din), .din_fs(din_fs),
    .path_def(path_def), .path_inh(path_inh),
    .los_def(los_def), .los_inh(los_inh),
    .loc_def(loc_def), .loc_inh(loc_inh),
    .force_ais(force_ais), .ext_ais_req(ext_ais_req),
    .dout(dout), .dout_fs(dout_fs),
    .ais_active(ais_active), .ais_change(ais_change)
  );

  typedef struct {
    logic [7:0] d;
    logic       fs;
    logic       act;
    logic       chg;
    int         row;
    int         col;
  } exp_t;

  exp_t  exp_q[$];
  int    checks = 0;
  int    errors = 0;
  int    seq = 0;
  int    mrow = 8;
  int    mcol = 89;
  logic  mais = 1'b0;
  string ctx = "base";
  bit    done = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s) actual %0h expected %0h", req, ctx, act, expv);
    end
  endtask

  // driver: applies one byte and pushes the expected result
  task automatic drive_byte(input logic fs);
    exp_t e;
    logic g;
    din    = 8'(seq * 37 + 11);
    din_fs = fs;
    seq++;
    if (fs) begin
      mrow = 0; mcol = 0;
    end else if (mcol == 89) begin
      mcol = 0;
      mrow = (mrow == 8) ? 0 : mrow + 1;
    end else begin
      mcol++;
    end
    g = (|(path_def & ~path_inh)) | (|(los_def & ~los_inh)) |
        (|(loc_def & ~loc_inh)) | force_ais | ext_ais_req;
    e.chg = fs && (g != mais);
    if (fs) mais = g;
    e.d   = (mais && ((mrow == 3 && mcol < 3) || mcol >= 3)) ? 8'hFF : din;
    e.fs  = fs;
    e.act = mais;
    e.row = mrow;
    e.col = mcol;
    exp_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic send(input int n, input bit fs_first);
    for (int i = 0; i < n; i++) drive_byte(fs_first && (i == 0));
  endtask

  // monitor: pops and compares every output byte
  initial begin
    exp_t e;
    string tag;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        if (e.row == 3 && e.col < 3 && e.act) tag = "R7";
        else if (e.col >= 3 && e.act) tag = "R8";
        else tag = "R9";
        check(dout == e.d, tag, dout, e.d);
        check(dout_fs == e.fs, "R10", dout_fs, e.fs);
        check(ais_active == e.act, "R11", ais_active, e.act);
        check(ais_change == e.chg, "R11", ais_change, e.chg);
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL R10 watchdog: actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; din = 8'h00; din_fs = 1'b0;
    path_def = '0; path_inh = '0; los_def = '0; los_inh = '0;
    loc_def = '0; loc_inh = '0; force_ais = 1'b0; ext_ais_req = 1'b0;
    repeat (3) @(negedge clk);
    ctx = "reset";
    check(dout == 8'h00, "R1", dout, 0);
    check(dout_fs == 1'b0, "R1", dout_fs, 0);
    check(ais_active == 1'b0, "R1", ais_active, 0);
    check(ais_change == 1'b0, "R1", ais_change, 0);
    rst_n = 1'b1;

    ctx = "clean";
    send(810, 1);
    check(ais_active == 1'b0, "R9", ais_active, 0);

    ctx = "path";
    path_def = 7'b0000100; send(810, 1);
    check(ais_active == 1'b1, "R2", ais_active, 1);
    path_inh = 7'b0000100; send(810, 1);
    check(ais_active == 1'b0, "R2", ais_active, 0);
    path_def = 7'b1000000; path_inh = 7'b0111111; send(810, 1);
    check(ais_active == 1'b1, "R2", ais_active, 1);
    path_def = '0; path_inh = '0;

    ctx = "sync_clock";
    los_def = 4'b0010; los_inh = 4'b0010; send(810, 1);
    check(ais_active == 1'b0, "R3", ais_active, 0);
    los_inh = 4'b1101; send(810, 1);
    check(ais_active == 1'b1, "R3", ais_active, 1);
    los_def = '0; loc_def = 3'b100; loc_inh = 3'b011; send(810, 1);
    check(ais_active == 1'b1, "R3", ais_active, 1);
    loc_inh = 3'b100; send(810, 1);
    check(ais_active == 1'b0, "R3", ais_active, 0);
    loc_def = '0; loc_inh = '0;

    ctx = "force";
    path_def = '1; path_inh = '1; los_def = '1; los_inh = '1;
    loc_def = '1; loc_inh = '1; send(810, 1);
    check(ais_active == 1'b0, "R4", ais_active, 0);
    force_ais = 1'b1; send(810, 1);
    check(ais_active == 1'b1, "R4", ais_active, 1);
    force_ais = 1'b0;

    ctx = "external";
    ext_ais_req = 1'b1; send(810, 1);
    check(ais_active == 1'b1, "R5", ais_active, 1);
    ext_ais_req = 1'b0;
    path_def = '0; path_inh = '0; los_def = '0; los_inh = '0;
    loc_def = '0; loc_inh = '0;
    send(810, 1);

    ctx = "mid_frame";
    send(400, 1);
    path_def = 7'b0000001; send(410, 0);
    check(ais_active == 1'b0, "R6", ais_active, 0);
    send(810, 1);
    check(ais_active == 1'b1, "R6", ais_active, 1);
    send(300, 1);
    path_def = '0; send(510, 0);
    check(ais_active == 1'b1, "R6", ais_active, 1);
    send(810, 1);
    check(ais_active == 1'b0, "R6", ais_active, 0);

    ctx = "R12";
    force_ais = 1'b1; send(810, 1);
    force_ais = 1'b0; send(810, 0);
    check(ais_active == 1'b1, "R12", ais_active, 1);
    send(500, 1);
    send(810, 1);
    check(ais_active == 1'b0, "R12", ais_active, 0);
    ext_ais_req = 1'b1; send(810, 1);
    ext_ais_req = 1'b0; send(810, 1);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R10", exp_q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule